// File: doc/BRIEF.md
# Paged Indirect 32-bit Bus Bridge

This block connects a 16-bit management register port to a 32-bit internal register bus. Each management access carries a PHY address, a 5-bit register number, a read or write strobe and 16 bits of write data. The block answers on a contiguous range of PHY addresses. A global page register selects what the register numbers mean. When the bridge page is selected, a group of registers holds the two halves of a write address, a write data word and a read address. It also holds the two halves of the last read result.

Software writes the low half of the write data to launch a 32-bit write on the internal bus. It writes the low half of the read address to launch a 32-bit read. The internal bus uses a request/acknowledge handshake. An optional mode steps the used address by the word stride after every completed transfer. A read-modify-write is built from one full read and one full write. While a transfer is pending the block reports busy and refuses updates to its holding registers, so the stored result cannot be corrupted.

Top module: `paged_bus_bridge`

## Requirements
- R1: After reset the page is 0, the step mode is off, every address, data and result holding register reads 0, `bus_req` and `mg_busy` are low, and `mg_rdata` is 0.
- R2: Register 0x1f holds the page number in bits [2:0] and reads back zero above them. One write at any answered PHY address (PHY_BASE to PHY_BASE+NUM_PHY-1) changes the page seen at all answered addresses. Writes to other PHY addresses have no effect, and reads from them return 0.
- R3: Only on page 4 do registers 0x10 to 0x18 exist. 0x10 is the mode register, with bit 15 = 1 meaning step and 0 meaning fixed. 0x11/0x12 are the write address upper/lower, 0x13/0x14 the write data upper/lower, 0x15/0x16 the read address upper/lower. On any other page, writes to 0x10-0x18 are ignored and reads return 0.
- R4: Writing 0x14 on page 4 starts one bus write with `bus_we`=1. The address is {0x11,0x12} and the data is {0x13, the value just written}.
- R5: Writing 0x16 on page 4 starts one bus read with `bus_we`=0 at {0x15, the value just written}. The `bus_rdata` seen with the acknowledge is kept: its upper half reads at 0x17 and its lower half at 0x18.
- R6: `bus_req` rises in the cycle after the launching write. It stays high with stable address, direction and data until `bus_ack` is seen, and falls in the next cycle.
- R7: In step mode, the address pair used by a transfer grows by 4 as one 32-bit value (carry into the upper half) when the transfer completes. In fixed mode it is unchanged. The other address pair is never affected.
- R8: While a transfer is pending, `mg_busy` is high. Writes to 0x10-0x16 are ignored, including launch writes, and 0x17/0x18 keep the previous result until the acknowledge.
- R9: Reads of any register never start a bus transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mg_phy | input | PHY_AW | PHY address of the management access |
| mg_reg | input | 5 | Register number |
| mg_wr | input | 1 | Write strobe, one cycle |
| mg_rd | input | 1 | Read strobe, one cycle |
| mg_wdata | input | 16 | Write data |
| mg_rdata | output | 16 | Read data, valid the cycle after `mg_rd` |
| mg_busy | output | 1 | Internal transfer pending |
| bus_req | output | 1 | Internal bus request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 32 | Internal byte address |
| bus_wdata | output | 32 | Internal write data |
| bus_ack | input | 1 | Transfer acknowledge, one cycle |
| bus_rdata | input | 32 | Read data, valid with `bus_ack` |

## Verification
Writes are tried with distinct halves in every holding register. This shows whether the launch takes the freshly written low half or a stale one, and whether the upper halves end up in the right place. Reads return an address-dependent word from the bench slave, so swapped halves or a wrong address show up directly. Step mode starts from an address of 0x0000FFFC, which separates a true 32-bit increment from a 16-bit one. A long-latency read with writes arriving during the wait tells a correctly frozen bridge from one that relaunches or overwrites its result. A read, mask and write sequence checks that the two primitives combine into a correct update.

// File: rtl/pbb_pkg.sv
// Shared register numbers, bus width and types for the paged bridge.
package pbb_pkg;
    localparam int MG_DW  = 16;
    localparam int BUS_W  = 32;

    localparam logic [4:0] R_PAGE  = 5'h1f;
    localparam logic [4:0] R_MODE  = 5'h10;
    localparam logic [4:0] R_WA_HI = 5'h11;
    localparam logic [4:0] R_WA_LO = 5'h12;
    localparam logic [4:0] R_WD_HI = 5'h13;
    localparam logic [4:0] R_WD_LO = 5'h14;
    localparam logic [4:0] R_RA_HI = 5'h15;
    localparam logic [4:0] R_RA_LO = 5'h16;
    localparam logic [4:0] R_RD_HI = 5'h17;
    localparam logic [4:0] R_RD_LO = 5'h18;

    localparam int MODE_STEP_BIT = 15;

    typedef enum logic {XF_IDLE, XF_WAIT} xfer_state_t;

    typedef struct packed {
        logic             we;
        logic [BUS_W-1:0] addr;
        logic [BUS_W-1:0] data;
    } bus_cmd_t;
endpackage

// File: rtl/pbb_page_ctl.sv
// Page selection and PHY address matching.
// Holds one page register shared by every answered PHY address.
// Assumes strobes are single-cycle and the PHY range does not wrap.
module pbb_page_ctl #(
    parameter int PHY_AW   = 5,
    parameter int PHY_BASE = 8,
    parameter int NUM_PHY  = 4,
    parameter int PAGE_W   = 3,
    parameter int WIN_PAGE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PHY_AW-1:0] mg_phy,
    input  logic [4:0]        mg_reg,
    input  logic              mg_wr,
    input  logic [PAGE_W-1:0] page_wdata,
    output logic              phy_hit,
    output logic [PAGE_W-1:0] page_q,
    output logic              win_open
);
    import pbb_pkg::*;

    localparam int PHY_LAST = PHY_BASE + NUM_PHY - 1;

    // Match the access against the answered PHY range.
    always_comb begin
        phy_hit = (int'(mg_phy) >= PHY_BASE) && (int'(mg_phy) <= PHY_LAST);
    end

    // Global page register, written from any answered address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q <= '0;
        end else if (mg_wr && phy_hit && mg_reg == R_PAGE) begin
            page_q <= page_wdata;
        end
    end

    assign win_open = (page_q == PAGE_W'(WIN_PAGE));
endmodule

// File: rtl/pbb_window_regs.sv
// Holding registers of the bridge window: mode, write address,
// write data, read address and captured read result.
// Produces the launch command when a trigger half is written.
// Assumes win_wr is already qualified by PHY match and page.
module pbb_window_regs #(
    parameter int ADDR_STRIDE = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     win_wr,
    input  logic [4:0]               mg_reg,
    input  logic [pbb_pkg::MG_DW-1:0] mg_wdata,
    input  logic                     busy,
    input  logic                     xfer_done,
    input  logic                     done_we,
    input  logic [pbb_pkg::BUS_W-1:0] bus_rdata,
    output logic                     step_mode,
    output logic [pbb_pkg::BUS_W-1:0] wr_addr,
    output logic [pbb_pkg::BUS_W-1:0] wr_data,
    output logic [pbb_pkg::BUS_W-1:0] rd_addr,
    output logic [pbb_pkg::BUS_W-1:0] rd_hold,
    output logic                     launch,
    output pbb_pkg::bus_cmd_t        launch_cmd
);
    import pbb_pkg::*;

    localparam int HALF = MG_DW;
    localparam logic [BUS_W-1:0] STEP = BUS_W'(ADDR_STRIDE);

    logic accept;

    // Writes are taken only while no transfer is pending.
    assign accept = win_wr && !busy;

    // Decide whether this write launches a transfer and form its command.
    always_comb begin
        launch          = accept && (mg_reg == R_WD_LO || mg_reg == R_RA_LO);
        launch_cmd.we   = (mg_reg == R_WD_LO);
        launch_cmd.addr = launch_cmd.we ? wr_addr : {rd_addr[BUS_W-1:HALF], mg_wdata};
        launch_cmd.data = {wr_data[BUS_W-1:HALF], mg_wdata};
    end

    // Holding register updates from management writes and transfer completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_mode <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
            rd_addr   <= '0;
            rd_hold   <= '0;
        end else begin
            if (accept) begin
                case (mg_reg)
                    R_MODE:  step_mode                <= mg_wdata[MODE_STEP_BIT];
                    R_WA_HI: wr_addr[BUS_W-1:HALF]    <= mg_wdata;
                    R_WA_LO: wr_addr[HALF-1:0]        <= mg_wdata;
                    R_WD_HI: wr_data[BUS_W-1:HALF]    <= mg_wdata;
                    R_WD_LO: wr_data[HALF-1:0]        <= mg_wdata;
                    R_RA_HI: rd_addr[BUS_W-1:HALF]    <= mg_wdata;
                    R_RA_LO: rd_addr[HALF-1:0]        <= mg_wdata;
                    default: ;
                endcase
            end
            if (xfer_done) begin
                if (done_we) begin
                    if (step_mode) wr_addr <= wr_addr + STEP;
                end else begin
                    rd_hold <= bus_rdata;
                    if (step_mode) rd_addr <= rd_addr + STEP;
                end
            end
        end
    end
endmodule

// File: rtl/pbb_xfer_master.sv
// Single-outstanding request/acknowledge master.
// Registers the launch command, holds it until the acknowledge,
// and flags completion in the acknowledge cycle.
// Assumes launch never arrives while busy (guarded upstream).
module pbb_xfer_master (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      launch,
    input  pbb_pkg::bus_cmd_t         launch_cmd,
    input  logic                      bus_ack,
    output logic                      bus_req,
    output logic                      bus_we,
    output logic [pbb_pkg::BUS_W-1:0] bus_addr,
    output logic [pbb_pkg::BUS_W-1:0] bus_wdata,
    output logic                      busy,
    output logic                      xfer_done,
    output logic                      done_we
);
    import pbb_pkg::*;

    xfer_state_t state_q;
    bus_cmd_t    cmd_q;

    // Request state and captured command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= XF_IDLE;
            cmd_q   <= '0;
        end else begin
            case (state_q)
                XF_IDLE: if (launch) begin
                    state_q <= XF_WAIT;
                    cmd_q   <= launch_cmd;
                end
                XF_WAIT: if (bus_ack) state_q <= XF_IDLE;
                default: state_q <= XF_IDLE;
            endcase
        end
    end

    // Drive the bus from the held command.
    always_comb begin
        bus_req   = (state_q == XF_WAIT);
        busy      = bus_req;
        bus_we    = cmd_q.we;
        bus_addr  = cmd_q.addr;
        bus_wdata = cmd_q.data;
        xfer_done = bus_req && bus_ack;
        done_we   = cmd_q.we;
    end
endmodule

// File: rtl/paged_bus_bridge.sv
// Top of the paged bridge: management port in, 32-bit bus master out.
// Ties page control, window registers and transfer master together
// and registers the management read data.
module paged_bus_bridge #(
    parameter int PHY_AW      = 5,
    parameter int PHY_BASE    = 8,
    parameter int NUM_PHY     = 4,
    parameter int PAGE_W      = 3,
    parameter int WIN_PAGE    = 4,
    parameter int ADDR_STRIDE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PHY_AW-1:0] mg_phy,
    input  logic [4:0]        mg_reg,
    input  logic              mg_wr,
    input  logic              mg_rd,
    input  logic [15:0]       mg_wdata,
    output logic [15:0]       mg_rdata,
    output logic              mg_busy,
    output logic              bus_req,
    output logic              bus_we,
    output logic [31:0]       bus_addr,
    output logic [31:0]       bus_wdata,
    input  logic              bus_ack,
    input  logic [31:0]       bus_rdata
);
    import pbb_pkg::*;

    localparam int HALF = MG_DW;

    logic              phy_hit;
    logic [PAGE_W-1:0] page_q;
    logic              win_open;
    logic              win_wr;
    logic              step_mode;
    logic [BUS_W-1:0]  wr_addr, wr_data, rd_addr, rd_hold;
    logic              launch;
    bus_cmd_t          launch_cmd;
    logic              busy, xfer_done, done_we;
    logic [MG_DW-1:0]  rd_val;

    pbb_page_ctl #(
        .PHY_AW(PHY_AW), .PHY_BASE(PHY_BASE), .NUM_PHY(NUM_PHY),
        .PAGE_W(PAGE_W), .WIN_PAGE(WIN_PAGE)
    ) u_page (
        .clk(clk), .rst_n(rst_n), .mg_phy(mg_phy), .mg_reg(mg_reg),
        .mg_wr(mg_wr), .page_wdata(mg_wdata[PAGE_W-1:0]),
        .phy_hit(phy_hit), .page_q(page_q), .win_open(win_open)
    );

    // Window writes need an answered address and the bridge page.
    assign win_wr = mg_wr && phy_hit && win_open;

    pbb_window_regs #(.ADDR_STRIDE(ADDR_STRIDE)) u_regs (
        .clk(clk), .rst_n(rst_n), .win_wr(win_wr), .mg_reg(mg_reg),
        .mg_wdata(mg_wdata), .busy(busy), .xfer_done(xfer_done),
        .done_we(done_we), .bus_rdata(bus_rdata), .step_mode(step_mode),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_hold(rd_hold), .launch(launch), .launch_cmd(launch_cmd)
    );

    pbb_xfer_master u_xfer (
        .clk(clk), .rst_n(rst_n), .launch(launch), .launch_cmd(launch_cmd),
        .bus_ack(bus_ack), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .busy(busy),
        .xfer_done(xfer_done), .done_we(done_we)
    );

    assign mg_busy = busy;

    // Select the readable value for the addressed register.
    always_comb begin
        rd_val = '0;
        if (mg_reg == R_PAGE) begin
            rd_val = MG_DW'(page_q);
        end else if (win_open) begin
            case (mg_reg)
                R_MODE:  rd_val = {step_mode, {(MG_DW-1){1'b0}}};
                R_WA_HI: rd_val = wr_addr[BUS_W-1:HALF];
                R_WA_LO: rd_val = wr_addr[HALF-1:0];
                R_WD_HI: rd_val = wr_data[BUS_W-1:HALF];
                R_WD_LO: rd_val = wr_data[HALF-1:0];
                R_RA_HI: rd_val = rd_addr[BUS_W-1:HALF];
                R_RA_LO: rd_val = rd_addr[HALF-1:0];
                R_RD_HI: rd_val = rd_hold[BUS_W-1:HALF];
                R_RD_LO: rd_val = rd_hold[HALF-1:0];
                default: rd_val = '0;
            endcase
        end
    end

    // Register the read data on each read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mg_rdata <= '0;
        end else if (mg_rd) begin
            mg_rdata <= phy_hit ? rd_val : '0;
        end
    end
endmodule

// File: rtl/paged_bus_bridge_checker.sv
// Protocol and state properties of the paged bridge, bound to its top.
module paged_bus_bridge_checker #(
    parameter int PAGE_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mg_wr,
    input logic [4:0]        mg_reg,
    input logic [PAGE_W-1:0] page_wdata,
    input logic              phy_hit,
    input logic              win_open,
    input logic [PAGE_W-1:0] page_q,
    input logic              mg_busy,
    input logic              bus_req,
    input logic              bus_we,
    input logic [31:0]       bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              bus_ack,
    input logic [31:0]       rd_hold
);
    import pbb_pkg::*;

    assert_hold_request_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));

    assert_release_after_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_ack |=> !bus_req);

    assert_result_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(mg_busy && bus_ack) |=> $stable(rd_hold));

    assert_page_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mg_wr && phy_hit && mg_reg == R_PAGE |=> page_q == $past(page_wdata));

    assert_foreign_phy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(mg_wr && phy_hit) |=> $stable(page_q));

    assert_launch_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> $past(mg_wr && phy_hit && win_open &&
                                 (mg_reg == R_WD_LO || mg_reg == R_RA_LO)));
endmodule

bind paged_bus_bridge paged_bus_bridge_checker #(.PAGE_W(PAGE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .mg_wr(mg_wr), .mg_reg(mg_reg),
    .page_wdata(mg_wdata[PAGE_W-1:0]), .phy_hit(phy_hit), .win_open(win_open),
    .page_q(page_q), .mg_busy(mg_busy), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
    .rd_hold(rd_hold)
);

// File: tb/paged_bus_bridge_test.sv
// Directed bench for the paged bridge with a latency-programmable slave.
module paged_bus_bridge_test;
    localparam logic [4:0] PB = 5'd8;   // first answered PHY address

    logic        clk = 0;
    logic        rst_n = 0;
    logic [4:0]  mg_phy = 0, mg_reg = 0;
    logic        mg_wr = 0, mg_rd = 0;
    logic [15:0] mg_wdata = 0;
    logic [15:0] mg_rdata;
    logic        mg_busy, bus_req, bus_we, bus_ack;
    logic [31:0] bus_addr, bus_wdata, bus_rdata;

    int n_chk = 0, n_bad = 0;
    int lat = 3, cnt = 0, txn = 0;
    logic [31:0] log_addr, log_data;
    logic        log_we;

    always #10 clk = ~clk;

    paged_bus_bridge uut (
        .clk(clk), .rst_n(rst_n), .mg_phy(mg_phy), .mg_reg(mg_reg),
        .mg_wr(mg_wr), .mg_rd(mg_rd), .mg_wdata(mg_wdata), .mg_rdata(mg_rdata),
        .mg_busy(mg_busy), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
        .bus_rdata(bus_rdata)
    );

    function automatic logic [31:0] model(input logic [31:0] a);
        return {a[15:0] ^ 16'h5A5A, a[31:16] + 16'h1234};
    endfunction

    // Bus slave: acknowledges after lat waiting cycles and logs the transfer.
    always @(posedge clk) begin
        if (!rst_n) begin
            bus_ack <= 0; cnt <= 0; bus_rdata <= 0;
        end else if (bus_ack) begin
            bus_ack <= 0; cnt <= 0;
        end else if (bus_req) begin
            if (cnt >= lat) begin
                bus_ack <= 1; bus_rdata <= model(bus_addr);
                log_addr <= bus_addr; log_we <= bus_we; log_data <= bus_wdata;
                txn <= txn + 1;
            end else cnt <= cnt + 1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic mg_write(input logic [4:0] phy, input logic [4:0] rn, input logic [15:0] d);
        @(negedge clk);
        mg_phy = phy; mg_reg = rn; mg_wdata = d; mg_wr = 1;
        @(negedge clk);
        mg_wr = 0;
    endtask

    task automatic mg_read(input logic [4:0] phy, input logic [4:0] rn, output logic [15:0] v);
        @(negedge clk);
        mg_phy = phy; mg_reg = rn; mg_rd = 1;
        @(negedge clk);
        mg_rd = 0;
        v = mg_rdata;
    endtask

    task automatic wait_idle();
        int g = 0;
        while (mg_busy && g < 2000) begin
            @(negedge clk); g++;
        end
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        check("R1 mg_rdata", 32'(mg_rdata), 0);
        check("R1 bus_req", 32'(bus_req), 0);
        check("R1 mg_busy", 32'(mg_busy), 0);
        mg_read(PB, 5'h1f, v); check("R1 page", 32'(v), 0);
        mg_write(PB, 5'h1f, 16'h0004);
        for (int r = 16; r <= 24; r++) begin
            mg_read(PB, 5'(r), v); check("R1 window reg", 32'(v), 0);
        end
    endtask

    task automatic t_page();
        logic [15:0] v;
        mg_read(PB + 5'd3, 5'h1f, v); check("R2 global page", 32'(v), 4);
        mg_write(PB + 5'd4, 5'h1f, 16'h0001);
        mg_read(PB + 5'd1, 5'h1f, v); check("R2 foreign write ignored", 32'(v), 4);
        mg_read(5'd3, 5'h1f, v); check("R2 foreign read zero", 32'(v), 0);
        mg_write(PB + 5'd2, 5'h1f, 16'hFFF5);
        mg_read(PB, 5'h1f, v); check("R2 page bits", 32'(v), 5);
        mg_write(PB, 5'h1f, 16'h0004);
    endtask

    task automatic t_window();
        logic [15:0] v;
        mg_write(PB, 5'h11, 16'h1111); mg_write(PB, 5'h12, 16'h2222);
        mg_write(PB, 5'h13, 16'h3333); mg_write(PB, 5'h15, 16'h5555);
        mg_read(PB, 5'h11, v); check("R3 wa hi", 32'(v), 32'h1111);
        mg_read(PB, 5'h12, v); check("R3 wa lo", 32'(v), 32'h2222);
        mg_read(PB, 5'h13, v); check("R3 wd hi", 32'(v), 32'h3333);
        mg_read(PB, 5'h15, v); check("R3 ra hi", 32'(v), 32'h5555);
        mg_write(PB, 5'h1f, 16'h0001);
        mg_write(PB, 5'h11, 16'hDEAD);
        mg_read(PB, 5'h11, v); check("R3 hidden on page 1", 32'(v), 0);
        mg_write(PB, 5'h1f, 16'h0004);
        mg_read(PB, 5'h11, v); check("R3 page 1 write ignored", 32'(v), 32'h1111);
    endtask

    task automatic t_write();
        int t0 = txn;
        mg_write(PB, 5'h11, 16'h1020); mg_write(PB, 5'h12, 16'h0304);
        mg_write(PB, 5'h13, 16'hCAFE); mg_write(PB + 5'd1, 5'h14, 16'hF00D);
        wait_idle();
        check("R4 one write", 32'(txn - t0), 1);
        check("R4 we", 32'(log_we), 1);
        check("R4 addr", log_addr, 32'h1020_0304);
        check("R4 data", log_data, 32'hCAFE_F00D);
    endtask

    task automatic t_read();
        logic [15:0] v;
        int t0 = txn;
        mg_write(PB, 5'h15, 16'h2000); mg_write(PB, 5'h16, 16'h0040);
        wait_idle();
        check("R5 one read", 32'(txn - t0), 1);
        check("R5 we", 32'(log_we), 0);
        check("R5 addr", log_addr, 32'h2000_0040);
        mg_read(PB, 5'h17, v); check("R5 data hi", 32'(v), 32'(model(32'h2000_0040) >> 16));
        mg_read(PB, 5'h18, v); check("R5 data lo", 32'(v), 32'(model(32'h2000_0040) & 32'hFFFF));
        mg_read(PB, 5'h16, v); check("R7 fixed mode keeps addr", 32'(v), 32'h0040);
    endtask

    task automatic t_hold();
        int n = 0, bad = 0;
        lat = 6;
        mg_write(PB, 5'h11, 16'h4000); mg_write(PB, 5'h12, 16'h0100);
        mg_write(PB, 5'h14, 16'h0042);
        while (bus_req && n < 100) begin
            if (bus_addr !== 32'h4000_0100 || bus_we !== 1'b1) bad++;
            n++;
            @(negedge clk);
        end
        check("R6 stable while waiting", 32'(bad), 0);
        check("R6 request length", 32'(n), 32'(lat + 2));
        check("R6 released", 32'(bus_req), 0);
        lat = 3;
    endtask

    task automatic t_step();
        logic [15:0] v;
        mg_write(PB, 5'h10, 16'h8000);
        mg_read(PB, 5'h10, v); check("R3 mode readback", 32'(v), 32'h8000);
        mg_write(PB, 5'h11, 16'h0000); mg_write(PB, 5'h12, 16'hFFFC);
        mg_write(PB, 5'h14, 16'h5555); wait_idle();
        check("R7 first write addr", log_addr, 32'h0000_FFFC);
        mg_read(PB, 5'h11, v); check("R7 carry hi", 32'(v), 1);
        mg_read(PB, 5'h12, v); check("R7 carry lo", 32'(v), 0);
        mg_write(PB, 5'h15, 16'h1000); mg_write(PB, 5'h16, 16'h0010); wait_idle();
        mg_read(PB, 5'h16, v); check("R7 read addr stepped", 32'(v), 32'h0014);
        mg_read(PB, 5'h11, v); check("R7 write pair untouched", 32'(v), 1);
        mg_write(PB, 5'h10, 16'h0000);
    endtask

    task automatic t_busy();
        logic [15:0] v;
        int t0;
        mg_write(PB, 5'h15, 16'h2000); mg_write(PB, 5'h16, 16'h0040); wait_idle();
        lat = 30;
        t0 = txn;
        mg_write(PB, 5'h15, 16'h3000); mg_write(PB, 5'h16, 16'h0080);
        check("R8 busy flag", 32'(mg_busy), 1);
        mg_write(PB, 5'h15, 16'h7777); mg_write(PB, 5'h16, 16'h8888);
        mg_read(PB, 5'h17, v); check("R8 old result kept", 32'(v), 32'(model(32'h2000_0040) >> 16));
        wait_idle();
        check("R8 no relaunch", 32'(txn - t0), 1);
        check("R8 address of launch", log_addr, 32'h3000_0080);
        mg_read(PB, 5'h15, v); check("R8 ra hi protected", 32'(v), 32'h3000);
        mg_read(PB, 5'h16, v); check("R8 ra lo protected", 32'(v), 32'h0080);
        mg_read(PB, 5'h18, v); check("R8 new result", 32'(v), 32'(model(32'h3000_0080) & 32'hFFFF));
        lat = 3;
    endtask

    task automatic t_noside();
        logic [15:0] v;
        int t0 = txn;
        mg_read(PB, 5'h17, v); mg_read(PB, 5'h14, v); mg_read(PB, 5'h16, v);
        @(negedge clk);
        check("R9 reads launch nothing", 32'(txn - t0), 0);
        check("R9 no request", 32'(bus_req), 0);
    endtask

    task automatic t_rmw();
        logic [15:0] hi, lo;
        logic [31:0] nv;
        mg_write(PB, 5'h15, 16'h5000); mg_write(PB, 5'h16, 16'h0008); wait_idle();
        mg_read(PB, 5'h17, hi); mg_read(PB, 5'h18, lo);
        nv = ({hi, lo} & ~32'h0000_FF00) | 32'h0000_1200;
        mg_write(PB, 5'h11, 16'h5000); mg_write(PB, 5'h12, 16'h0008);
        mg_write(PB, 5'h13, nv[31:16]); mg_write(PB, 5'h14, nv[15:0]); wait_idle();
        check("R5 rmw read value", {hi, lo}, model(32'h5000_0008));
        check("R4 rmw written value", log_data, (model(32'h5000_0008) & ~32'h0000_FF00) | 32'h0000_1200);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset(); t_page(); t_window(); t_write(); t_read();
        t_hold(); t_step(); t_busy(); t_noside(); t_rmw();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule